// File: doc/BRIEF.md
# Serial Loader for an External Clock Synthesizer

This block programs an off-chip frequency synthesizer over two wires: a serial clock line and a serial data line. When a start request arrives, it captures a band index and three divider values (N, P, D) and packs them into one 24-bit control word. It then plays a fixed sequence of line states onto the two wires. The sequence is an unlock preamble, a start bit, the 24 word bits in a complement-then-true encoding, and a stop bit. The whole sequence runs three times back to back.

Every line state holds for a fixed number of system clocks, set by a parameter. This keeps the wire rate within what the synthesizer accepts. When the last repetition ends, the block pulses a done flag, returns both wires to their idle high level, and sets a 4-bit clock-select output to the register slot that has just been loaded. The surrounding logic then steers its pixel clock mux from that output.

Top module: `synth_loader`

## Requirements
- R1: After reset, and whenever the block is not busy, both wires are high, busy and done are low. The clock-select output reads 0 after reset.
- R2: The word is, from MSB down, a 3-bit slot code of value 2 (bits 23:21), the band index (20:17), N (16:10), P (9:7) and D (6:0). It is sent bit 0 first.
- R3: Each repetition opens with a preamble of 14 (data, clock) states: (0,0), then (1,0), then five pairs (1,1),(1,0), then (0,0),(0,1).
- R4: The preamble is followed by a start bit of two states, (0,0) then (0,1).
- R5: Each word bit takes four states. A 1 is sent as (0,1),(0,0),(1,0),(1,1). A 0 is sent as (1,1),(1,0),(0,0),(0,1). The inverted bit is therefore on data at the falling clock edge, and the true bit is on data at the rising clock edge.
- R6: After bit 23 comes a stop bit of three states, (1,1),(1,0),(1,1).
- R7: The 115-state sequence is played PASSES times (3 by default) with no gap between repetitions.
- R8: Every state holds for exactly TICK_DIV system clocks (TICK_DIV ≥ 1).
- R9: A start is accepted on a clock edge where start is high and busy is low. From that edge on, busy is high and the first state is on the wires. Exactly 115·PASSES·TICK_DIV cycles later, busy falls and done pulses for one cycle.
- R10: A start seen while busy has no effect on the sequence.
- R11: The band and divider inputs are sampled only when a start is accepted; later changes do not alter the transfer in progress.
- R12: The clock-select output drops to 0 on an accepted start, becomes 2 in the cycle done is high, and holds that value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a programming run |
| band_i | input | 4 | Band index placed in the word |
| n_i | input | 7 | N divider value |
| p_i | input | 3 | P post-divider value |
| d_i | input | 7 | D divider value |
| syn_clk_o | output | 1 | Serial clock wire to the synthesizer |
| syn_data_o | output | 1 | Serial data wire to the synthesizer |
| busy_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| sel_o | output | 4 | Clock-select index for the pixel clock mux |

## Verification
The bench builds two copies side by side, one with TICK_DIV=2 and one with TICK_DIV=1, both with three repetitions. The divide-by-two copy tests that every state is held for its repeat cycles and that the counter wraps between states. The divide-by-one copy runs with the pacing counter bypassed, so a state change occurs on every clock and the finishing edge coincides with a state advance. Because the two copies end at different times, a request held high re-arms one copy while the other is still busy. This exercises both the rejection of a start and the immediate re-acceptance after done.

// File: rtl/synld_pkg.sv
package synld_pkg;

  localparam int BAND_W   = 4;
  localparam int NDIV_W   = 7;
  localparam int PDIV_W   = 3;
  localparam int DDIV_W   = 7;
  localparam int WORD_W   = 24;
  localparam int SEL_W    = 4;

  localparam logic [2:0]       SLOT_CODE  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_LOADED = 4'd2;

  localparam int UNLOCK_RISES = 5;
  localparam int PRE_LEN      = 2 + 2 * UNLOCK_RISES + 2;
  localparam int START_LEN    = 2;
  localparam int BIT_PHASES   = 4;
  localparam int STOP_LEN     = 3;
  localparam int DATA_BASE    = PRE_LEN + START_LEN;
  localparam int STOP_BASE    = DATA_BASE + BIT_PHASES * WORD_W;
  localparam int XFER_LEN     = STOP_BASE + STOP_LEN;
  localparam int STEP_W       = $clog2(XFER_LEN);

  typedef struct packed {
    logic data;
    logic sclk;
  } line_t;

  localparam line_t LINE_IDLE = '{data: 1'b1, sclk: 1'b1};

  function automatic logic [WORD_W-1:0] pack_word(
    input logic [BAND_W-1:0] band,
    input logic [NDIV_W-1:0] ndiv,
    input logic [PDIV_W-1:0] pdiv,
    input logic [DDIV_W-1:0] ddiv
  );
    return {SLOT_CODE, band, ndiv, pdiv, ddiv};
  endfunction

  // Line state for a step index inside one repetition.
  function automatic line_t wave_at(
    input logic [STEP_W-1:0] step,
    input logic [WORD_W-1:0] word
  );
    int    s;
    int    k;
    int    ph;
    logic  b;
    logic [4:0] bi;
    line_t r;
    s = int'(step);
    r = LINE_IDLE;
    if (s == 0) begin
      r = '{data: 1'b0, sclk: 1'b0};
    end else if (s < PRE_LEN - 2) begin
      r.data = 1'b1;
      r.sclk = (s % 2 == 0);
    end else if (s == PRE_LEN - 2 || s == PRE_LEN) begin
      r = '{data: 1'b0, sclk: 1'b0};
    end else if (s == PRE_LEN - 1 || s == PRE_LEN + 1) begin
      r = '{data: 1'b0, sclk: 1'b1};
    end else if (s < STOP_BASE) begin
      k  = s - DATA_BASE;
      ph = k % BIT_PHASES;
      bi = 5'(k / BIT_PHASES);
      b  = word[bi];
      r.sclk = (ph == 0 || ph == 3);
      r.data = (ph < 2) ? ~b : b;
    end else begin
      r.data = 1'b1;
      r.sclk = (s != STOP_BASE + 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/synld_pacer.sv
module synld_pacer #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  generate
    if (TICK_DIV <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_count
      localparam int CW = $clog2(TICK_DIV);
      localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
      logic [CW-1:0] cnt_q;

      assign tick = run && (cnt_q == LAST);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (!run || tick) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end

      // each state spans several clocks, so two ticks never touch
      assert_tick_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/synld_stepper.sv
module synld_stepper
  import synld_pkg::*;
#(
  parameter int PASSES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              tick,
  output logic              busy_q,
  output logic              busy_d,
  output logic [STEP_W-1:0] step_d,
  output logic              finish_d,
  output logic              done_q
);

  localparam int PW = (PASSES > 1) ? $clog2(PASSES) : 1;
  localparam logic [PW-1:0]     LAST_PASS = PW'(PASSES - 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(XFER_LEN - 1);

  logic [STEP_W-1:0] step_q;
  logic [PW-1:0]     pass_q;
  logic [PW-1:0]     pass_d;

  always_comb begin
    busy_d   = busy_q;
    step_d   = step_q;
    pass_d   = pass_q;
    finish_d = 1'b0;
    if (accept) begin
      busy_d = 1'b1;
      step_d = '0;
      pass_d = '0;
    end else if (busy_q && tick) begin
      if (step_q == LAST_STEP) begin
        step_d = '0;
        if (pass_q == LAST_PASS) begin
          busy_d   = 1'b0;
          finish_d = 1'b1;
        end else begin
          pass_d = pass_q + 1'b1;
        end
      end else begin
        step_d = step_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= '0;
      pass_q <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      step_q <= step_d;
      pass_q <= pass_d;
      done_q <= finish_d;
    end
  end

  assert_pass_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (pass_q <= LAST_PASS));

  assert_done_closes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q)));

  // no restart of the position while a run is active and no tick is due
  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick) |=> ($stable(step_q) && $stable(pass_q)));

endmodule

// File: rtl/synld_wave.sv
module synld_wave
  import synld_pkg::*;
(
  input  logic              active,
  input  logic [STEP_W-1:0] step,
  input  logic [WORD_W-1:0] word,
  output line_t             line
);

  assign line = active ? wave_at(step, word) : LINE_IDLE;

endmodule

// File: rtl/synth_loader.sv
module synth_loader
  import synld_pkg::*;
#(
  parameter int TICK_DIV = 4,
  parameter int PASSES   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [BAND_W-1:0] band_i,
  input  logic [NDIV_W-1:0] n_i,
  input  logic [PDIV_W-1:0] p_i,
  input  logic [DDIV_W-1:0] d_i,
  output logic              syn_clk_o,
  output logic              syn_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [SEL_W-1:0]  sel_o
);

  logic              accept;
  logic              tick;
  logic              busy_q;
  logic              busy_d;
  logic [STEP_W-1:0] step_d;
  logic              finish_d;
  logic              done_q;
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] word_d;
  line_t             line_d;
  line_t             line_q;
  logic [SEL_W-1:0]  sel_q;

  assign accept = start_i && !busy_q;
  assign word_d = accept ? pack_word(band_i, n_i, p_i, d_i) : word_q;

  synld_pacer #(.TICK_DIV(TICK_DIV)) u_pacer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy_q),
    .tick (tick)
  );

  synld_stepper #(.PASSES(PASSES)) u_stepper (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .tick    (tick),
    .busy_q  (busy_q),
    .busy_d  (busy_d),
    .step_d  (step_d),
    .finish_d(finish_d),
    .done_q  (done_q)
  );

  synld_wave u_wave (
    .active(busy_d),
    .step  (step_d),
    .word  (word_d),
    .line  (line_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      line_q <= LINE_IDLE;
      sel_q  <= '0;
    end else begin
      word_q <= word_d;
      line_q <= line_d;
      if (accept) begin
        sel_q <= '0;
      end else if (finish_d) begin
        sel_q <= SEL_LOADED;
      end
    end
  end

  assign syn_clk_o  = line_q.sclk;
  assign syn_data_o = line_q.data;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign sel_o      = sel_q;

  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (syn_clk_o && syn_data_o));

  assert_word_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(word_q));

  assert_sel_loaded_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (sel_o == SEL_LOADED));

  assert_sel_cleared_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (sel_o == '0));

endmodule

// File: tb/sim_synth_loader.sv
module synld_refmodel #(
  parameter int T      = 1,
  parameter int PASSES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [3:0] band,
  input  logic [6:0] nv,
  input  logic [2:0] pv,
  input  logic [6:0] dv,
  input  logic       w_clk,
  input  logic       w_data,
  input  logic       busy,
  input  logic       done,
  input  logic [3:0] sel,
  output int         checks,
  output int         errs
);

  logic [1:0]  q_ln[$];
  string       q_tg[$];
  int          q_smp[$];
  logic        m_busy = 1'b0;
  logic        m_done = 1'b0;
  logic        m_clk  = 1'b1;
  logic        m_data = 1'b1;
  logic [3:0]  m_sel  = 4'd0;
  string       cur_tg = "R1";
  int          cur_smp = -1;
  logic [23:0] exp_w = '0;
  logic [23:0] got_w = '0;
  logic [3:0]  c_band;
  logic [6:0]  c_n;
  logic [2:0]  c_p;
  logic [6:0]  c_d;
  bit          changed = 1'b0;
  int          acc_cnt = 0;
  int          done_seen = 0;

  initial begin
    checks = 0;
    errs   = 0;
  end

  task automatic put(input logic dd, input logic cc, input string tg, input int smp);
    for (int r = 0; r < T; r++) begin
      q_ln.push_back({dd, cc});
      q_tg.push_back(r == 0 ? tg : "R8");
      q_smp.push_back(r == 0 ? smp : -1);
    end
  endtask

  task automatic build();
    int val;
    val = 2 * (2 ** 21) + int'(band) * (2 ** 17) + int'(nv) * (2 ** 10)
        + int'(pv) * (2 ** 7) + int'(dv);
    exp_w = val[23:0];
    for (int ps = 0; ps < PASSES; ps++) begin
      string ta, tb, tc, te;
      ta = (ps == 0) ? "R3" : "R7";
      tb = (ps == 0) ? "R4" : "R7";
      tc = (ps == 0) ? "R5" : "R7";
      te = (ps == 0) ? "R6" : "R7";
      put(1'b0, 1'b0, ta, -1);
      put(1'b1, 1'b0, ta, -1);
      for (int i = 0; i < 5; i++) begin
        put(1'b1, 1'b1, ta, -1);
        put(1'b1, 1'b0, ta, -1);
      end
      put(1'b0, 1'b0, ta, -1);
      put(1'b0, 1'b1, ta, -1);
      put(1'b0, 1'b0, tb, -1);
      put(1'b0, 1'b1, tb, -1);
      for (int k = 0; k < 24; k++) begin
        if (exp_w[k]) begin
          put(1'b0, 1'b1, tc, -1);
          put(1'b0, 1'b0, tc, -1);
          put(1'b1, 1'b0, tc, -1);
          put(1'b1, 1'b1, tc, k);
        end else begin
          put(1'b1, 1'b1, tc, -1);
          put(1'b1, 1'b0, tc, -1);
          put(1'b0, 1'b0, tc, -1);
          put(1'b0, 1'b1, tc, k);
        end
      end
      put(1'b1, 1'b1, te, -1);
      put(1'b1, 1'b0, te, -1);
      put(1'b1, 1'b1, te, -1);
    end
  endtask

  task automatic pop();
    logic [1:0] e;
    e = q_ln.pop_front();
    m_data  = e[1];
    m_clk   = e[0];
    cur_tg  = q_tg.pop_front();
    cur_smp = q_smp.pop_front();
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q_ln.delete(); q_tg.delete(); q_smp.delete();
      m_busy = 1'b0; m_done = 1'b0; m_clk = 1'b1; m_data = 1'b1;
      m_sel = 4'd0; cur_tg = "R1"; cur_smp = -1;
    end else begin
      m_done = 1'b0;
      if (m_busy) begin
        if (band != c_band || nv != c_n || pv != c_p || dv != c_d) changed = 1'b1;
        if (q_ln.size() > 0) begin
          pop();
        end else begin
          m_busy = 1'b0; m_done = 1'b1; m_sel = 4'd2;
          m_clk = 1'b1; m_data = 1'b1; cur_tg = "R9"; cur_smp = -1;
        end
      end else if (start) begin
        c_band = band; c_n = nv; c_p = pv; c_d = dv;
        changed = 1'b0;
        build();
        m_busy = 1'b1; m_sel = 4'd0;
        acc_cnt++;
        pop();
      end else begin
        m_clk = 1'b1; m_data = 1'b1; cur_tg = "R1"; cur_smp = -1;
      end
    end
  end

  task automatic chk(input bit ok, input string tg, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s (div %0d) at %0t: actual %0h expected %0h", tg, T, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk({w_data, w_clk} == {m_data, m_clk}, cur_tg, {w_data, w_clk}, {m_data, m_clk});
      chk(busy == m_busy, "R9", busy, m_busy);
      chk(done == m_done, "R9", done, m_done);
      chk(sel == m_sel, "R12", sel, m_sel);
      if (cur_smp >= 0) begin
        got_w[cur_smp] = w_data;
        if (cur_smp == 23) chk(got_w == exp_w, changed ? "R11" : "R2", got_w, exp_w);
      end
      if (done) begin
        done_seen++;
        chk(done_seen == acc_cnt, "R10", done_seen, acc_cnt);
      end
    end
  end

endmodule

module sim_synth_loader;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] band = '0;
  logic [6:0] nv = '0;
  logic [2:0] pv = '0;
  logic [6:0] dv = '0;

  logic       a_clk, a_data, a_busy, a_done;
  logic [3:0] a_sel;
  logic       b_clk, b_data, b_busy, b_done;
  logic [3:0] b_sel;
  int         a_chk, a_err, b_chk, b_err;
  int         n_chk = 0;
  int         n_err = 0;

  always #5 clk = ~clk;

  synth_loader #(.TICK_DIV(2), .PASSES(3)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .band_i(band), .n_i(nv), .p_i(pv), .d_i(dv),
    .syn_clk_o(a_clk), .syn_data_o(a_data), .busy_o(a_busy), .done_o(a_done), .sel_o(a_sel)
  );

  synth_loader #(.TICK_DIV(1), .PASSES(3)) u1 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .band_i(band), .n_i(nv), .p_i(pv), .d_i(dv),
    .syn_clk_o(b_clk), .syn_data_o(b_data), .busy_o(b_busy), .done_o(b_done), .sel_o(b_sel)
  );

  synld_refmodel #(.T(2), .PASSES(3)) m0 (
    .clk(clk), .rst_n(rst_n), .start(start), .band(band), .nv(nv), .pv(pv), .dv(dv),
    .w_clk(a_clk), .w_data(a_data), .busy(a_busy), .done(a_done), .sel(a_sel),
    .checks(a_chk), .errs(a_err)
  );

  synld_refmodel #(.T(1), .PASSES(3)) m1 (
    .clk(clk), .rst_n(rst_n), .start(start), .band(band), .nv(nv), .pv(pv), .dv(dv),
    .w_clk(b_clk), .w_data(b_data), .busy(b_busy), .done(b_done), .sel(b_sel),
    .checks(b_chk), .errs(b_err)
  );

  task automatic check(input bit ok, input string tg, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tg, $time, act, exp);
    end
  endtask

  task automatic launch(input logic [3:0] b, input logic [6:0] n, input logic [2:0] p,
                        input logic [6:0] d);
    @(negedge clk);
    band = b; nv = n; pv = p; dv = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (a_busy || b_busy);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk + a_chk + b_chk, n_err + a_err + b_err);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state on both copies
    check({a_clk, a_data} == 2'b11, "R1", {a_clk, a_data}, 2'b11);
    check({b_clk, b_data} == 2'b11, "R1", {b_clk, b_data}, 2'b11);
    check(!a_busy && !a_done && !b_busy && !b_done, "R1", {a_busy, a_done, b_busy, b_done}, 0);
    check(a_sel == 4'd0 && b_sel == 4'd0, "R1", {a_sel, b_sel}, 0);

    launch(4'h5, 7'h55, 3'h3, 7'h2A);
    wait_idle();
    launch(4'hF, 7'h7F, 3'h7, 7'h7F);
    wait_idle();
    launch(4'h0, 7'h00, 3'h0, 7'h00);
    wait_idle();

    // R10 and R11: extra start and field changes in mid-run
    launch(4'h9, 7'h12, 3'h5, 7'h61);
    repeat (40) @(negedge clk);
    start = 1'b1; band = 4'h6; nv = 7'h3C; pv = 3'h2; dv = 7'h0F;
    @(negedge clk);
    start = 1'b0;
    repeat (100) @(negedge clk);
    band = 4'hA; nv = 7'h01; dv = 7'h40;
    wait_idle();

    // start held high: re-acceptance directly after done
    @(negedge clk);
    band = 4'h3; nv = 7'h2B; pv = 3'h6; dv = 7'h19; start = 1'b1;
    do @(negedge clk); while (!a_done);
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    repeat (5) @(negedge clk);
    check(a_sel == 4'd2 && b_sel == 4'd2, "R12", {a_sel, b_sel}, 8'h22);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

endmodule